// File: doc/BRIEF.md
# Receive Page Ring Manager

This block owns the write side of a circular receive buffer kept in local buffer memory. The buffer is made of 256-byte pages. The ring begins at the page held in `pageStart`, and `pageStop` names the first page that lies outside it. A receive writer reports three kinds of event: the start of a packet, each byte it stores, and the end of the packet. The block turns these events into a 16-bit local write address. It also keeps the current page pointer, which is the page where the next packet will begin.

Every packet begins on a page boundary. When a packet ends, the current page moves to the page after the last byte that was written, so the unused tail of that page is skipped. Both during a packet and at its end, the page after the last ring page is the first ring page. A host-written `boundary` page marks the oldest packet that has not yet been read. If the write side would advance into that page, the block raises `overflow`, drops the rest of the packet, and leaves the current page unchanged.

Top module: `rx_ring_mgr`

## Requirements
- R1: While `rstN` is low, each clock loads `curPage` from `pageStart` and clears `overflow`. After reset is released, `wrAddr` is {`pageStart`, 8'h00} until the first event.
- R2: Outside a packet, `wrAddr` equals {`curPage`, 8'h00}.
- R3: A `pktStart` makes `wrAddr` equal {`curPage`, 8'h00} on the next cycle. While the packet is accepted, each `byteWr` raises `wrAddr` by one on the next cycle.
- R4: After `pktEnd`, `curPage` is the page that follows the page holding the last written byte. A packet whose length is an exact multiple of 256 moves `curPage` forward by exactly that many pages. A packet with no bytes leaves `curPage` unchanged.
- R5: When the write page or the end page would become `pageStop`, it becomes `pageStart` instead. The data of a wrapped packet continues at {`pageStart`, 8'h00}.
- R6: An advance into a page equal to `boundary` sets `overflow` on the next cycle. This applies both on the byte at offset 8'hFF and at `pktEnd`. The packet is then dropped, and `curPage` does not change when that packet ends.
- R7: In a dropped packet, `byteWr` is ignored and `wrAddr` holds its value.
- R8: `overflow` stays high until the next `pktStart` and is low in the cycle after it.
- R9: Simultaneous events are handled in priority order: `pktStart` over `pktEnd` over `byteWr`. A `pktStart` during a packet abandons that packet and does not move `curPage`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| pageStart | input | 8 | First page of the ring |
| pageStop | input | 8 | First page past the ring |
| boundary | input | 8 | Host boundary page (oldest unread packet) |
| pktStart | input | 1 | Packet start event |
| byteWr | input | 1 | One byte stored at `wrAddr` |
| pktEnd | input | 1 | Packet end event |
| wrAddr | output | 16 | Local buffer write address |
| curPage | output | 8 | Current page pointer |
| overflow | output | 1 | Ring overflow flag |

## Verification
Every result is registered, so the effect of an event sampled at one rising edge appears at the outputs right after that edge. The bench drives events on falling edges. A behavioural model steps at each rising edge, and the outputs are compared with the model on the following falling edge, one cycle after the stimulus. The directed checks of pointer values, wrap, overflow and event priority are taken on the falling edge after the event's rising edge has completed.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  typedef struct packed {
    logic ldStart;
    logic incOff;
    logic advPage;
    logic commitEnd;
  } ringStrobe_t;

  typedef struct packed {
    logic offMax;
    logic offZero;
    logic advHit;
  } ringFlag_t;

  typedef enum logic [1:0] {RING_IDLE, RING_RECV, RING_DROP} ringState_t;
endpackage

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pktStart,
  input  logic        byteWr,
  input  logic        pktEnd,
  input  ringFlag_t   flags,
  output ringStrobe_t strobe,
  output logic        busy,
  output logic        overflow
);
  ringState_t state, stateNxt;
  logic setOvf;

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    setOvf   = 1'b0;
    if (pktStart) begin
      strobe.ldStart = 1'b1;
      stateNxt = RING_RECV;
    end else if (pktEnd) begin
      if (state == RING_RECV) begin
        if (!flags.offZero && flags.advHit) setOvf = 1'b1;
        else strobe.commitEnd = 1'b1;
      end
      stateNxt = RING_IDLE;
    end else if (byteWr && state == RING_RECV) begin
      if (!flags.offMax) begin
        strobe.incOff = 1'b1;
      end else if (flags.advHit) begin
        setOvf   = 1'b1;
        stateNxt = RING_DROP;
      end else begin
        strobe.advPage = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= RING_IDLE;
      overflow <= 1'b0;
    end else begin
      state <= stateNxt;
      if (pktStart) overflow <= 1'b0;
      else if (setOvf) overflow <= 1'b1;
    end
  end

  assign busy = (state != RING_IDLE);
endmodule

// File: rtl/rxring_dp.sv
module rxring_dp
  import rxring_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PAGE_W-1:0] pageStart,
  input  logic [PAGE_W-1:0] pageStop,
  input  logic [PAGE_W-1:0] boundary,
  input  ringStrobe_t       strobe,
  input  logic              busy,
  output ringFlag_t         flags,
  output logic [PAGE_W-1:0] curPage,
  output logic [ADDR_W-1:0] wrAddr
);
  logic [PAGE_W-1:0] wrPage, nxtPage;
  logic [OFF_W-1:0]  offset;
  logic [PAGE_W:0]   pageInc;

  assign pageInc = {1'b0, wrPage} + 1'b1;
  assign nxtPage = (pageInc == {1'b0, pageStop}) ? pageStart : pageInc[PAGE_W-1:0];

  assign flags.offMax  = &offset;
  assign flags.offZero = (offset == '0);
  assign flags.advHit  = (nxtPage == boundary);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPage <= pageStart;
      wrPage  <= pageStart;
      offset  <= '0;
    end else begin
      if (strobe.ldStart) begin
        wrPage <= curPage;
        offset <= '0;
      end
      if (strobe.incOff) offset <= offset + 1'b1;
      if (strobe.advPage) begin
        wrPage <= nxtPage;
        offset <= '0;
      end
      if (strobe.commitEnd) curPage <= flags.offZero ? wrPage : nxtPage;
    end
  end

  assign wrAddr = busy ? {wrPage, offset} : {curPage, {OFF_W{1'b0}}};
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
  import rxring_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PAGE_W-1:0] pageStart,
  input  logic [PAGE_W-1:0] pageStop,
  input  logic [PAGE_W-1:0] boundary,
  input  logic              pktStart,
  input  logic              byteWr,
  input  logic              pktEnd,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [PAGE_W-1:0] curPage,
  output logic              overflow
);
  ringStrobe_t strobe;
  ringFlag_t   flags;
  logic        busy;

  rxring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pktStart(pktStart), .byteWr(byteWr), .pktEnd(pktEnd),
    .flags(flags), .strobe(strobe), .busy(busy), .overflow(overflow)
  );

  rxring_dp #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .pageStart(pageStart), .pageStop(pageStop),
    .boundary(boundary), .strobe(strobe), .busy(busy), .flags(flags),
    .curPage(curPage), .wrAddr(wrAddr)
  );
endmodule

// File: rtl/rxring_chk.sv
module rxring_chk #(
  parameter int PAGE_W = 8,
  parameter int OFF_W  = 8,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [PAGE_W-1:0] pageStart,
  input logic              pktStart,
  input logic              byteWr,
  input logic              pktEnd,
  input logic              busy,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [PAGE_W-1:0] curPage,
  input logic              overflow
);
  // R1
  reset_load_chk: assert property (@(posedge clk)
    !rstN |=> (curPage == $past(pageStart)) && !overflow);

  // R3
  start_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktStart |=> wrAddr == {$past(curPage), {OFF_W{1'b0}}});

  // R2
  idle_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pktEnd && !pktStart) |=> wrAddr == {curPage, {OFF_W{1'b0}}});

  // R3
  byte_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && byteWr && !pktStart && !pktEnd && !overflow && (&wrAddr[OFF_W-1:0] == 1'b0))
      |=> wrAddr == $past(wrAddr) + 1'b1);

  // R6
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !pktStart) |=> $stable(curPage));

  // R8
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktStart |=> !overflow);

  // R7
  drop_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && overflow && !pktStart && !pktEnd) |=> $stable(wrAddr));
endmodule

bind rx_ring_mgr rxring_chk #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rstN(rstN), .pageStart(pageStart), .pktStart(pktStart),
  .byteWr(byteWr), .pktEnd(pktEnd), .busy(busy), .wrAddr(wrAddr),
  .curPage(curPage), .overflow(overflow)
);

// File: tb/tb_rx_ring_mgr.sv
module tb_rx_ring_mgr;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] pageStart = 8'h40, pageStop = 8'h48, boundary = 8'h3F;
  logic pktStart = 1'b0, byteWr = 1'b0, pktEnd = 1'b0;
  logic [15:0] wrAddr;
  logic [7:0]  curPage;
  logic        overflow;

  int total = 0, bad = 0;
  string phaseReq = "R1";
  bit done = 0;

  rx_ring_mgr dut (.*);

  always #4 clk = ~clk;

  // behavioural reference: 0 idle, 1 receiving, 2 dropping
  int mState = 0, mCur = 'h40, mWp = 'h40, mOff = 0;
  bit mOvf = 0;

  function automatic int wrapNext(int p);
    return (p + 1 == int'(pageStop)) ? int'(pageStart) : p + 1;
  endfunction

  always @(posedge clk) begin
    int n;
    if (!rstN) begin
      mCur = pageStart; mWp = pageStart; mOff = 0; mState = 0; mOvf = 0;
    end else if (pktStart) begin
      mState = 1; mWp = mCur; mOff = 0; mOvf = 0;
    end else if (pktEnd) begin
      if (mState == 1) begin
        if (mOff == 0) mCur = mWp;
        else begin
          n = wrapNext(mWp);
          if (n == int'(boundary)) mOvf = 1; else mCur = n;
        end
      end
      mState = 0;
    end else if (byteWr && mState == 1) begin
      if (mOff < 255) mOff++;
      else begin
        n = wrapNext(mWp);
        if (n == int'(boundary)) begin mOvf = 1; mState = 2; end
        else begin mWp = n; mOff = 0; end
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(phaseReq, "wrAddr", wrAddr, (mState != 0) ? mWp * 256 + mOff : mCur * 256);
      check(phaseReq, "curPage", curPage, mCur);
      check(phaseReq, "overflow", overflow, mOvf);
    end
  end

  task automatic step(bit s, bit b, bit e);
    @(negedge clk);
    pktStart = s; byteWr = b; pktEnd = e;
  endtask

  task automatic bytes(int n);
    for (int i = 0; i < n; i++) step(0, 1, 0);
  endtask

  task automatic packet(int n);
    step(1, 0, 0); bytes(n); step(0, 0, 1); step(0, 0, 0);
  endtask

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "reset curPage", curPage, 'h40);
    check("R1", "reset wrAddr", wrAddr, 'h4000);
    check("R1", "reset overflow", overflow, 0);

    phaseReq = "R3";
    step(1, 0, 0); bytes(3); step(0, 0, 0);
    @(negedge clk);
    check("R3", "addr after 3 bytes", wrAddr, 'h4003);
    bytes(7); step(0, 0, 1); step(0, 0, 0); @(negedge clk);
    check("R4", "curPage after 10 bytes", curPage, 'h41);
    check("R2", "idle addr", wrAddr, 'h4100);

    phaseReq = "R4";
    packet(256); @(negedge clk);
    check("R4", "exact page packet", curPage, 'h42);
    packet(300); @(negedge clk);
    check("R4", "tail skipped", curPage, 'h44);
    packet(0); @(negedge clk);
    check("R4", "empty packet", curPage, 'h44);

    phaseReq = "R5";
    packet(256); packet(256); packet(256); @(negedge clk);
    check("R5", "before wrap", curPage, 'h47);
    step(1, 0, 0); bytes(256); step(0, 0, 0); @(negedge clk);
    check("R5", "wrapped addr", wrAddr, 'h4000);
    bytes(44); step(0, 0, 1); step(0, 0, 0); @(negedge clk);
    check("R5", "wrapped end page", curPage, 'h41);

    phaseReq = "R6";
    boundary = 8'h42;
    step(1, 0, 0); bytes(256); step(0, 0, 0); @(negedge clk);
    check("R6", "overflow on page advance", overflow, 1);
    check("R7", "frozen addr", wrAddr, 'h41FF);
    phaseReq = "R7";
    bytes(5); step(0, 0, 0); @(negedge clk);
    check("R7", "byte ignored in drop", wrAddr, 'h41FF);
    step(0, 0, 1); step(0, 0, 0); @(negedge clk);
    check("R6", "curPage kept", curPage, 'h41);
    check("R8", "overflow sticky", overflow, 1);

    phaseReq = "R8";
    step(1, 0, 0); step(0, 0, 0); @(negedge clk);
    check("R8", "overflow cleared by start", overflow, 0);
    phaseReq = "R6";
    bytes(10); step(0, 0, 1); step(0, 0, 0); @(negedge clk);
    check("R6", "end-advance overflow", overflow, 1);
    check("R6", "end-advance curPage kept", curPage, 'h41);

    phaseReq = "R9";
    boundary = 8'h3F;
    step(1, 0, 0); bytes(5); step(1, 0, 1); step(0, 0, 0); @(negedge clk);
    check("R9", "start wins over end", wrAddr, 'h4100);
    check("R9", "abandoned packet keeps page", curPage, 'h41);
    bytes(4); step(0, 1, 1); step(0, 0, 0); @(negedge clk);
    check("R9", "end wins over byte", curPage, 'h42);
    check("R9", "idle after end", wrAddr, 'h4200);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule